// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block moves parallel data between two ports, A and B, one storage element per direction. The forward path takes data from A and presents it on B. The reverse path takes data from B and presents it on A. Each storage element is controlled by a pass control and a strobe, and can work in three ways. With pass high it is transparent. With pass low and no strobe edge it holds its value. With pass low, a rising strobe edge captures the input. Data is never inverted. Each output port has its own drive enable, and the two enables have opposite polarity.

All controls are synchronous inputs, sampled by the system clock. Strobe edges are found by comparing each sample with the one before. Each physical bus is split into an input half, a flag that says whether something outside drives that half, and an output half with its own drive enable. When no outside driver is present, a keeper presents the last valid level of that bus to the storage. If both directions try to drive at the same time, a clash flag is raised and neither storage element captures.

Top module: `dual_reg_transceiver`

## Requirements
- R1: While `rst` is high at a clock edge, both storage elements and both keepers clear to zero, so `b_out` and `a_out` read zero after that edge. Reset does not change the behaviour of `b_out_en` or `a_out_en`.
- R2: Forward transparent mode. If `fwd_pass` is high and there is no clash at an edge, `b_out` equals the effective A value one clock later.
- R3: Forward hold. If `fwd_pass` is low and there is no rising `fwd_strobe` edge, `b_out` stays unchanged, whatever A carries.
- R4: Forward edge capture. If `fwd_pass` is low and `fwd_strobe` is sampled high after a low sample, the effective A value is stored. During reset the previous-sample register takes the current strobe level, so a strobe that is already high when reset is released makes no edge.
- R5: `b_out_en` is active high and registered: it equals `fwd_drive_en` sampled at the previous edge.
- R6: `a_out_en` is registered and driven by the active-low `rev_drive_n`: it is high one clock after `rev_drive_n` is sampled low.
- R7: The reverse path uses `rev_pass` and `rev_strobe` in the same three ways. It stores the effective B value and presents it on `a_out`.
- R8: Data is non-inverting and keeps bit order: bit i of an output equals bit i of the input value it stored.
- R9: When an input-valid flag is low, the effective value of that bus is the last effective value at the previous edge (zero after reset). A stored value taken then equals that held value.
- R10: When `fwd_drive_en` is high and `rev_drive_n` is low at an edge, `clash` is high one clock later and neither storage element changes at that edge. Otherwise `clash` is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_drive_en | input | 1 | B port drive enable, active high |
| rev_drive_n | input | 1 | A port drive enable, active low |
| fwd_pass | input | 1 | Forward transparent control |
| rev_pass | input | 1 | Reverse transparent control |
| fwd_strobe | input | 1 | Forward capture strobe (rising edge) |
| rev_strobe | input | 1 | Reverse capture strobe (rising edge) |
| a_in | input | WIDTH | A bus level from outside |
| a_in_valid | input | 1 | An outside driver is present on A |
| b_in | input | WIDTH | B bus level from outside |
| b_in_valid | input | 1 | An outside driver is present on B |
| a_out | output | WIDTH | Reverse stored data toward A |
| a_out_en | output | 1 | A port driven |
| b_out | output | WIDTH | Forward stored data toward B |
| b_out_en | output | 1 | B port driven |
| clash | output | 1 | Both ports were enabled at the last edge |

## Verification
The checker assumes the strobes are slow compared with the system clock, so each strobe level lasts at least one sample. This lets every intended edge be seen as a low sample followed by a high one. The transparency properties are checked only in cycles where the input-valid flag is high, because only then does the port value equal the effective value. The stimulus holds each strobe level for at least one full cycle and changes every input at the falling clock edge. It also holds the keeper and clash cases long enough that each starts and ends cleanly.

// File: rtl/txr_pkg.sv
package txr_pkg;
   typedef enum logic [1:0] {
      CAP_KEEP = 2'd0,
      CAP_PASS = 2'd1,
      CAP_EDGE = 2'd2
   } cap_e;

   function automatic cap_e pick_cap(input logic pass, input logic rise, input logic block);
      if (block)     return CAP_KEEP;
      else if (pass) return CAP_PASS;
      else if (rise) return CAP_EDGE;
      else           return CAP_KEEP;
   endfunction
endpackage

// File: rtl/txr_bus_keep.sv
module txr_bus_keep #(
   parameter int WIDTH   = 18,
   parameter bit KEEP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] pin_val,
   input  logic             pin_driven,
   output logic [WIDTH-1:0] eff_val
);
   generate
      if (KEEP_EN) begin : g_keep
         logic [WIDTH-1:0] last_q;
         assign eff_val = pin_driven ? pin_val : last_q;
         always_ff @(posedge clk) begin
            if (rst) last_q <= '0;
            else     last_q <= eff_val;
         end
      end else begin : g_wire
         assign eff_val = pin_val;
      end
   endgenerate
endmodule

// File: rtl/txr_lane.sv
module txr_lane
   import txr_pkg::*;
#(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pass,
   input  logic             strobe,
   input  logic             block,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic             strobe_prev_q;
   logic             rise;
   cap_e             cap;
   logic [WIDTH-1:0] store_q;

   assign rise = strobe & ~strobe_prev_q;
   assign cap  = pick_cap(pass, rise, block);
   assign dout = store_q;

   always_ff @(posedge clk) begin
      strobe_prev_q <= strobe;
      if (rst) begin
         store_q <= '0;
      end else begin
         case (cap)
            CAP_PASS, CAP_EDGE: store_q <= din;
            default:            store_q <= store_q;
         endcase
      end
   end
endmodule

// File: rtl/dual_reg_transceiver.sv
module dual_reg_transceiver #(
   parameter int WIDTH   = 18,
   parameter bit KEEP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fwd_drive_en,
   input  logic             rev_drive_n,
   input  logic             fwd_pass,
   input  logic             rev_pass,
   input  logic             fwd_strobe,
   input  logic             rev_strobe,
   input  logic [WIDTH-1:0] a_in,
   input  logic             a_in_valid,
   input  logic [WIDTH-1:0] b_in,
   input  logic             b_in_valid,
   output logic [WIDTH-1:0] a_out,
   output logic             a_out_en,
   output logic [WIDTH-1:0] b_out,
   output logic             b_out_en,
   output logic             clash
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dual_reg_transceiver: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_eff;
   logic [WIDTH-1:0] b_eff;
   logic             both_on;
   logic             b_en_q;
   logic             a_en_q;
   logic             clash_q;

   assign both_on = fwd_drive_en & ~rev_drive_n;

   txr_bus_keep #(.WIDTH(WIDTH), .KEEP_EN(KEEP_EN)) u_keep_a (
      .clk(clk), .rst(rst), .pin_val(a_in), .pin_driven(a_in_valid), .eff_val(a_eff)
   );
   txr_bus_keep #(.WIDTH(WIDTH), .KEEP_EN(KEEP_EN)) u_keep_b (
      .clk(clk), .rst(rst), .pin_val(b_in), .pin_driven(b_in_valid), .eff_val(b_eff)
   );

   txr_lane #(.WIDTH(WIDTH)) u_fwd (
      .clk(clk), .rst(rst), .pass(fwd_pass), .strobe(fwd_strobe),
      .block(both_on), .din(a_eff), .dout(b_out)
   );
   txr_lane #(.WIDTH(WIDTH)) u_rev (
      .clk(clk), .rst(rst), .pass(rev_pass), .strobe(rev_strobe),
      .block(both_on), .din(b_eff), .dout(a_out)
   );

   always_ff @(posedge clk) begin
      b_en_q  <= fwd_drive_en;
      a_en_q  <= ~rev_drive_n;
      clash_q <= both_on;
   end

   assign b_out_en = b_en_q;
   assign a_out_en = a_en_q;
   assign clash    = clash_q;
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
   parameter int WIDTH = 18
) (
   input logic             clk,
   input logic             rst,
   input logic             fwd_drive_en,
   input logic             rev_drive_n,
   input logic             fwd_pass,
   input logic             rev_pass,
   input logic             fwd_strobe,
   input logic             rev_strobe,
   input logic [WIDTH-1:0] a_in,
   input logic             a_in_valid,
   input logic [WIDTH-1:0] b_in,
   input logic             b_in_valid,
   input logic [WIDTH-1:0] a_out,
   input logic             a_out_en,
   input logic [WIDTH-1:0] b_out,
   input logic             b_out_en,
   input logic             clash
);
   logic seen_f;
   logic seen_r;
   logic up_ok;
   logic both;

   always_ff @(posedge clk) begin
      seen_f <= fwd_strobe;
      seen_r <= rev_strobe;
      up_ok  <= 1'b1;
   end

   assign both = fwd_drive_en & ~rev_drive_n;

   // R1
   reset_clears_chk: assert property (@(posedge clk) rst |=> (b_out == '0 && a_out == '0));
   // R2
   fwd_transparent_chk: assert property (@(posedge clk) disable iff (rst)
      (fwd_pass && a_in_valid && !both) |=> (b_out == $past(a_in)));
   // R3
   fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (up_ok && !fwd_pass && !(fwd_strobe && !seen_f)) |=> $stable(b_out));
   // R5
   fwd_enable_chk: assert property (@(posedge clk) disable iff (rst)
      up_ok |=> (b_out_en == $past(fwd_drive_en)));
   // R6
   rev_enable_chk: assert property (@(posedge clk) disable iff (rst)
      up_ok |=> (a_out_en == !$past(rev_drive_n)));
   // R7
   rev_transparent_chk: assert property (@(posedge clk) disable iff (rst)
      (rev_pass && b_in_valid && !both) |=> (a_out == $past(b_in)));
   // R7
   rev_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (up_ok && !rev_pass && !(rev_strobe && !seen_r)) |=> $stable(a_out));
   // R10
   clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
      up_ok |=> (clash == $past(both)));
   // R10
   clash_guard_chk: assert property (@(posedge clk) disable iff (rst)
      (up_ok && both) |=> ($stable(b_out) && $stable(a_out)));
endmodule

bind dual_reg_transceiver txr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst(rst), .fwd_drive_en(fwd_drive_en), .rev_drive_n(rev_drive_n),
   .fwd_pass(fwd_pass), .rev_pass(rev_pass), .fwd_strobe(fwd_strobe),
   .rev_strobe(rev_strobe), .a_in(a_in), .a_in_valid(a_in_valid), .b_in(b_in),
   .b_in_valid(b_in_valid), .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out),
   .b_out_en(b_out_en), .clash(clash)
);

// File: tb/dual_reg_transceiver_bench.sv
module dual_reg_transceiver_bench;
   localparam int W = 18;

   typedef struct {
      logic [W-1:0] b_val;
      logic [W-1:0] a_val;
      logic         b_en;
      logic         a_en;
      logic         clash_v;
      string        tag_b;
      string        tag_a;
   } exp_t;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst = 1'b1;
   logic         fwd_drive_en = 1'b0, rev_drive_n = 1'b1;
   logic         fwd_pass = 1'b0, rev_pass = 1'b0;
   logic         fwd_strobe = 1'b0, rev_strobe = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         a_in_valid = 1'b1, b_in_valid = 1'b1;
   logic [W-1:0] a_out, b_out;
   logic         a_out_en, b_out_en, clash;

   dual_reg_transceiver #(.WIDTH(W)) u_dual_reg_transceiver (
      .clk(clk), .rst(rst), .fwd_drive_en(fwd_drive_en), .rev_drive_n(rev_drive_n),
      .fwd_pass(fwd_pass), .rev_pass(rev_pass), .fwd_strobe(fwd_strobe),
      .rev_strobe(rev_strobe), .a_in(a_in), .a_in_valid(a_in_valid), .b_in(b_in),
      .b_in_valid(b_in_valid), .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out),
      .b_out_en(b_out_en), .clash(clash)
   );

   exp_t q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   logic [W-1:0] m_sf = '0, m_sr = '0, m_ha = '0, m_hb = '0;
   logic         m_pf = 1'b0, m_pr = 1'b0;

   // driver: reference model from the requirements, one entry per clock edge
   task automatic tick(input string tb, input string ta);
      exp_t e;
      logic [W-1:0] ea, eb;
      logic cl;
      ea = a_in_valid ? a_in : m_ha;   // R9
      eb = b_in_valid ? b_in : m_hb;
      cl = fwd_drive_en && !rev_drive_n;
      if (rst) begin
         m_sf = '0; m_sr = '0; m_ha = '0; m_hb = '0;
      end else begin
         m_ha = ea; m_hb = eb;
         if (!cl) begin
            if (fwd_pass || (fwd_strobe && !m_pf)) m_sf = ea;
            if (rev_pass || (rev_strobe && !m_pr)) m_sr = eb;
         end
      end
      m_pf = fwd_strobe;
      m_pr = rev_strobe;
      e.b_val = m_sf; e.a_val = m_sr;
      e.b_en = fwd_drive_en; e.a_en = !rev_drive_n; e.clash_v = cl;
      e.tag_b = tb; e.tag_a = ta;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag_b, b_out, e.b_val);
         chk(e.tag_a, a_out, e.a_val);
         chk("R5 b_out_en", {{(W-1){1'b0}}, b_out_en}, {{(W-1){1'b0}}, e.b_en});
         chk("R6 a_out_en", {{(W-1){1'b0}}, a_out_en}, {{(W-1){1'b0}}, e.a_en});
         chk("R10 clash", {{(W-1){1'b0}}, clash}, {{(W-1){1'b0}}, e.clash_v});
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset with B enable asserted and A enable off
      rst = 1'b1; fwd_drive_en = 1'b1; rev_drive_n = 1'b1; a_in = 18'h3FFFF; fwd_pass = 1'b1;
      tick("R1 b_out", "R1 a_out");
      tick("R1 b_out", "R1 a_out");
      rst = 1'b0;
      // R2 / R8: transparent forward with several patterns
      a_in = 18'h15555; tick("R2 b_out", "R3 a_out");
      a_in = 18'h2AAAA; tick("R2 b_out", "R3 a_out");
      for (int i = 0; i < W; i += 5) begin
         a_in = 18'(1) << i; tick("R8 b_out", "R3 a_out");
      end
      a_in = 18'h0F0F3; tick("R2 b_out", "R3 a_out");
      // R3: hold with pass low, data toggling
      fwd_pass = 1'b0; a_in = 18'h12345; tick("R3 b_out", "R3 a_out");
      a_in = 18'h3C3C3; tick("R3 b_out", "R3 a_out");
      // R4: rising strobe captures, steady high holds
      fwd_strobe = 1'b1; a_in = 18'h2468A; tick("R4 b_out", "R3 a_out");
      a_in = 18'h11111; tick("R3 b_out", "R3 a_out");
      fwd_strobe = 1'b0; a_in = 18'h22222; tick("R3 b_out", "R3 a_out");
      fwd_strobe = 1'b1; a_in = 18'h33333; tick("R4 b_out", "R3 a_out");
      fwd_strobe = 1'b0; tick("R3 b_out", "R3 a_out");
      // R7 / R6: reverse path, A enabled (active low), B disabled
      fwd_drive_en = 1'b0; rev_drive_n = 1'b0;
      rev_pass = 1'b1; b_in = 18'h0ABCD; tick("R3 b_out", "R7 a_out");
      b_in = 18'h30001; tick("R3 b_out", "R7 a_out");
      rev_pass = 1'b0; b_in = 18'h1FFFE; tick("R3 b_out", "R7 a_out");
      rev_strobe = 1'b1; b_in = 18'h05A5A; tick("R3 b_out", "R7 a_out");
      b_in = 18'h00000; tick("R3 b_out", "R7 a_out");
      rev_strobe = 1'b0; tick("R3 b_out", "R7 a_out");
      // R9: keeper on A while no outside driver
      rev_drive_n = 1'b1; fwd_pass = 1'b1; a_in = 18'h13579; tick("R2 b_out", "R7 a_out");
      a_in_valid = 1'b0; a_in = 18'h3FFFF; tick("R9 b_out", "R7 a_out");
      a_in = 18'h00000; tick("R9 b_out", "R7 a_out");
      a_in_valid = 1'b1; a_in = 18'h0000F; tick("R2 b_out", "R7 a_out");
      // R9 on B via edge capture
      b_in_valid = 1'b0; b_in = 18'h3FFFF; rev_strobe = 1'b1; tick("R2 b_out", "R9 a_out");
      rev_strobe = 1'b0; b_in_valid = 1'b1; tick("R2 b_out", "R9 a_out");
      // R10: clash blocks both captures
      fwd_drive_en = 1'b1; rev_drive_n = 1'b0; rev_pass = 1'b1;
      a_in = 18'h2FFFF; b_in = 18'h1EEEE; tick("R10 b_out", "R10 a_out");
      tick("R10 b_out", "R10 a_out");
      rev_drive_n = 1'b1; tick("R2 b_out", "R7 a_out");
      rev_pass = 1'b0; fwd_pass = 1'b0;
      // R1 / R4: reset while strobe high, then no edge on release
      fwd_strobe = 1'b1; rst = 1'b1; a_in = 18'h1234F; tick("R1 b_out", "R1 a_out");
      rst = 1'b0; tick("R4 b_out", "R3 a_out");
      tick("R3 b_out", "R3 a_out");
      tick("R3 b_out", "R3 a_out");
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #40000;
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule